// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block models a synchronous static memory whose bus never idles when traffic switches between reads and writes. A command (address, direction, lane write mask) is captured on one rising clock edge, and its data phase happens during the following cycle: read data flows combinationally out of the array at the captured address, while write data is taken from the write-data input on the edge that closes that cycle. Because each data phase overlaps the next command's address phase, reads and writes can follow one another back to back.

Each word is split into byte lanes of nine bits, and each lane carries its own active-low write enable. Three chip selects gate the start of new work. An advance cycle repeats the direction of the running burst at an address supplied by a companion sequencer. A clock-enable input and a sleep input each freeze the whole block. An asynchronous output enable masks the read path at once. The bidirectional bus is split into a data-in port, a data-out port and a drive flag that an outer pad wrapper would use to turn its buffer on.

Top module: `zbt_sram_core`

## Requirements
- R1: A read command (load with `adv_ld`=0, chips selected, `rnw`=1) captured on an edge causes `drive_o`=1 in the following cycle, with `rdata_o` equal to the word stored at the captured address.
- R2: A write command captured on an edge writes lane k (data bits 9k+8 down to 9k) with `wdata_i` sampled on the next edge, for each k where `lane_we_n[k]`=0; lanes whose bit is 1 keep their old contents.
- R3: On an edge where `cken_n`=1 every other synchronous input is ignored: no command is captured, no pending write commits and `drive_o`/`rdata_o` stay as they were.
- R4: A new command starts only when `adv_ld`=0, `cs1_n`=0, `cs2`=1 and `cs3_n`=0.
- R5: A load cycle with any chip select false is a deselect: the data phase already pending still completes, and `drive_o`=0 in the cycle after the deselect.
- R6: In the cycle after a write command is captured, `drive_o`=0.
- R7: Lane write enables have no effect on read commands.
- R8: With `adv_ld`=1, if a burst is running (last load selected the chip), a new command of the same direction is captured at `addr_i` with freshly sampled lane enables; if no burst is running, the cycle is idle.
- R9: `oe_n`=1 forces `drive_o`=0 and `rdata_o`=0 at once, without waiting for a clock edge.
- R10: With `sleep`=1 the block holds exactly as for `cken_n`=1 and the array keeps its contents.
- R11: A write followed directly by a read of the same address returns the freshly written data in the read's data phase.
- R12: Synchronous reset (`rst`=1) cancels any pending data phase and any running burst, so `drive_o`=0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the command pipeline |
| addr_i | input | ADDR_W | Word address for a load or advance cycle |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| rnw | input | 1 | Direction of a load: 1 read, 0 write |
| adv_ld | input | 1 | 0 loads a new command, 1 advances a running burst |
| cken_n | input | 1 | Clock enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, freezes the block while high |
| wdata_i | input | LANES*LANE_W | Write data for the pending write phase |
| rdata_o | output | LANES*LANE_W | Flow-through read data, zero when not driving |
| drive_o | output | 1 | High when the read data must be driven on the bus |

## Verification
The checker watches, on every cycle, that output enable masks the drive flag, that a read load turns the drive on one cycle later, that writes and deselects leave the bus undriven in the next cycle, that clock-enable and sleep holds keep the outputs frozen, and that the bus is quiet right after reset. Only the bench scenarios can show data correctness: lane-masked writes, bursts walking the whole array, a read immediately after a write to the same word, and writes parked across holds landing with the right data.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  function automatic logic chips_on(input logic c1_n, input logic c2, input logic c3_n);
    return (~c1_n) & c2 & (~c3_n);
  endfunction

endpackage

// File: rtl/zbt_cmd_decode.sv
module zbt_cmd_decode
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              rnw,
  input  logic              adv_ld,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_we_n,
  input  op_e               burst_op,
  output op_e               nxt_op,
  output op_e               nxt_burst,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [LANES-1:0]  nxt_lanes
);

  logic selected;

  always_comb begin
    selected  = chips_on(cs1_n, cs2, cs3_n);
    nxt_op    = OP_IDLE;
    nxt_burst = burst_op;
    if (!adv_ld) begin
      if (selected) begin
        nxt_op    = rnw ? OP_READ : OP_WRITE;
        nxt_burst = nxt_op;
      end else begin
        nxt_op    = OP_IDLE;
        nxt_burst = OP_IDLE;
      end
    end else begin
      nxt_op = burst_op;
    end
    nxt_addr  = addr_i;
    nxt_lanes = (nxt_op == OP_WRITE) ? ~lane_we_n : '0;
  end

endmodule

// File: rtl/zbt_pipe_reg.sv
module zbt_pipe_reg
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  op_e               nxt_op,
  input  op_e               nxt_burst,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [LANES-1:0]  nxt_lanes,
  output op_e               pend_op,
  output op_e               burst_op,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [LANES-1:0]  pend_lanes
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_op    <= OP_IDLE;
      burst_op   <= OP_IDLE;
      pend_addr  <= '0;
      pend_lanes <= '0;
    end else if (step) begin
      pend_op    <= nxt_op;
      burst_op   <= nxt_burst;
      pend_addr  <= nxt_addr;
      pend_lanes <= nxt_lanes;
    end
  end

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_wr,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_wr[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[raddr];
  end

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    rnw,
  input  logic                    adv_ld,
  input  logic                    cken_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);

  localparam int DATA_W = LANES * LANE_W;

  logic              step;
  op_e               nxt_op, nxt_burst, pend_op, burst_op;
  logic [ADDR_W-1:0] nxt_addr, pend_addr;
  logic [LANES-1:0]  nxt_lanes, pend_lanes, lane_wr;
  logic [DATA_W-1:0] arr_rdata;

  // The whole block advances only on edges that are neither held nor asleep.
  assign step = ~cken_n & ~sleep;

  zbt_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .cs1_n     (cs1_n),
    .cs2       (cs2),
    .cs3_n     (cs3_n),
    .rnw       (rnw),
    .adv_ld    (adv_ld),
    .addr_i    (addr_i),
    .lane_we_n (lane_we_n),
    .burst_op  (burst_op),
    .nxt_op    (nxt_op),
    .nxt_burst (nxt_burst),
    .nxt_addr  (nxt_addr),
    .nxt_lanes (nxt_lanes)
  );

  zbt_pipe_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .nxt_op     (nxt_op),
    .nxt_burst  (nxt_burst),
    .nxt_addr   (nxt_addr),
    .nxt_lanes  (nxt_lanes),
    .pend_op    (pend_op),
    .burst_op   (burst_op),
    .pend_addr  (pend_addr),
    .pend_lanes (pend_lanes)
  );

  // A pending write commits on the edge that closes its data phase.
  assign lane_wr = (step && !rst && pend_op == OP_WRITE) ? pend_lanes : '0;

  zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .lane_wr (lane_wr),
    .waddr   (pend_addr),
    .wdata   (wdata_i),
    .raddr   (pend_addr),
    .rdata   (arr_rdata)
  );

  // Flow-through read path, masked asynchronously by the output enable.
  assign drive_o = (pend_op == OP_READ) & ~oe_n;
  assign rdata_o = drive_o ? arr_rdata : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cs1_n,
  input logic                    cs2,
  input logic                    cs3_n,
  input logic                    rnw,
  input logic                    adv_ld,
  input logic                    cken_n,
  input logic                    sleep,
  input logic                    oe_n,
  input logic                    drive_o,
  input logic [LANES*LANE_W-1:0] rdata_o
);

  logic sel, live;
  assign sel  = ~cs1_n & cs2 & ~cs3_n;
  assign live = ~cken_n & ~sleep;

  // R9: output enable masks the drive flag
  a_r9_oe_masks: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!drive_o && rdata_o == '0));

  // R1: a read load drives the bus in the next cycle
  a_r1_read_drives: assert property (@(posedge clk) disable iff (rst)
    (live && !adv_ld && sel && rnw) |=> (drive_o || oe_n));

  // R6: the cycle after a write command is undriven
  a_r6_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (live && !adv_ld && sel && !rnw) |=> !drive_o);

  // R5: the cycle after a deselect is undriven
  a_r5_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    (live && !adv_ld && !sel) |=> !drive_o);

  // R3: a clock-enable hold freezes the outputs
  a_r3_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    cken_n |=> (!$stable(oe_n) || ($stable(drive_o) && $stable(rdata_o))));

  // R10: sleep freezes the outputs
  a_r10_sleep_frozen: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!$stable(oe_n) || ($stable(drive_o) && $stable(rdata_o))));

  // R12: the bus is quiet right after a reset edge
  a_r12_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !drive_o);

endmodule

bind zbt_sram_core zbt_sram_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs1_n   (cs1_n),
  .cs2     (cs2),
  .cs3_n   (cs3_n),
  .rnw     (rnw),
  .adv_ld  (adv_ld),
  .cken_n  (cken_n),
  .sleep   (sleep),
  .oe_n    (oe_n),
  .drive_o (drive_o),
  .rdata_o (rdata_o)
);

// File: tb/zbt_sram_core_bench.sv
`timescale 1ns/1ps
module zbt_sram_core_bench;

  localparam int AW    = 6;
  localparam int LN    = 4;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_i;
  logic          cs1_n, cs2, cs3_n, rnw, adv_ld, cken_n, oe_n, sleep;
  logic [LN-1:0] lane_we_n;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  int checks = 0;
  int errors = 0;

  // reference state: 0 idle, 1 read, 2 write
  int            m_op, m_burst;
  logic [AW-1:0] m_addr;
  logic [LN-1:0] m_lanes;
  logic [DW-1:0] mem_ref [DEPTH];

  always #2.5 clk = ~clk;

  zbt_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_zbt_sram_core (
    .clk(clk), .rst(rst), .addr_i(addr_i), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .rnw(rnw), .adv_ld(adv_ld), .cken_n(cken_n),
    .lane_we_n(lane_we_n), .oe_n(oe_n), .sleep(sleep), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .drive_o(drive_o)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 36'h0_1234_5671) ^ 36'hA_5A5A_5A5A;
  endfunction

  function automatic logic exp_drive();
    return (m_op == 1) && !oe_n;
  endfunction

  function automatic logic [DW-1:0] exp_data();
    return exp_drive() ? mem_ref[m_addr] : '0;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic s;
    if (rst) begin
      m_op = 0; m_burst = 0;
    end else if (!cken_n && !sleep) begin
      if (m_op == 2)
        for (int k = 0; k < LN; k++)
          if (m_lanes[k]) mem_ref[m_addr][k*LW +: LW] = wdata_i[k*LW +: LW];
      s = !cs1_n && cs2 && !cs3_n;
      if (!adv_ld) begin
        m_op    = s ? (rnw ? 1 : 2) : 0;
        m_burst = m_op;
      end else begin
        m_op = m_burst;
      end
      m_addr  = addr_i;
      m_lanes = (m_op == 2) ? ~lane_we_n : '0;
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #0.1;
    check(tag, DW'(drive_o), DW'(exp_drive()));
    check(tag, rdata_o, exp_data());
  endtask

  task automatic cmd(input logic ld_n, input logic rd, input logic [AW-1:0] a,
                     input logic [LN-1:0] bw, input logic [DW-1:0] wd);
    cs1_n = 0; cs2 = 1; cs3_n = 0; cken_n = 0; sleep = 0;
    adv_ld = ld_n; rnw = rd; addr_i = a; lane_we_n = bw; wdata_i = wd;
  endtask

  task automatic desel(input logic [DW-1:0] wd);
    cmd(1'b0, 1'b1, '0, '1, wd);
    cs2 = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    oe_n = 0; rst = 1;
    desel('0);
    m_op = 0; m_burst = 0; m_addr = '0; m_lanes = '0;
    @(negedge clk);
    tick("R12");
    tick("R12");
    rst = 0;
    tick("R12");

    // R8: burst write fills the array, wdata carries the previous word
    for (int i = 0; i <= DEPTH; i++) begin
      if (i == 0)          cmd(1'b0, 1'b0, '0, '0, '0);
      else if (i < DEPTH)  cmd(1'b1, 1'b0, AW'(i), '0, pat(i - 1));
      else                 desel(pat(DEPTH - 1));
      tick("R8");
    end
    // R1/R8: burst read
    cmd(1'b0, 1'b1, '0, '1, '0); tick("R1");
    for (int i = 1; i < DEPTH; i++) begin
      cmd(1'b1, 1'b1, AW'(i), '1, '0); tick("R8");
    end
    desel('0); tick("R5");
    desel('0); tick("R5");
    // R8: advance with no running burst is idle
    cmd(1'b1, 1'b1, AW'(3), '1, '0); tick("R8");

    // R2: lanes 0 and 2 written (bits 0 and 2 low)
    cmd(1'b0, 1'b0, AW'(5), 4'b1010, '0); tick("R6");
    desel('1); tick("R2");
    cmd(1'b0, 1'b1, AW'(5), '1, '0); tick("R2");
    // R7: lane enables on a read change nothing
    cmd(1'b0, 1'b1, AW'(5), '0, 36'h0_DEAD_BEEF); tick("R7");
    cmd(1'b0, 1'b1, AW'(5), '1, 36'h0_DEAD_BEEF); tick("R7");
    // R11: write then read same address back to back
    cmd(1'b0, 1'b0, AW'(9), '0, '0); tick("R6");
    cmd(1'b0, 1'b1, AW'(9), '1, 36'h1_2345_6789); tick("R11");
    // R5: read then deselect, write then deselect commits
    cmd(1'b0, 1'b1, AW'(3), '1, '0); tick("R1");
    desel('0); tick("R5");
    cmd(1'b0, 1'b0, AW'(4), '0, '0); tick("R6");
    desel(36'h0_0F0F_0F0F); tick("R5");
    cmd(1'b0, 1'b1, AW'(4), '1, '0); tick("R5");

    // R3: hold with a parked read, then a parked write
    cmd(1'b0, 1'b1, AW'(2), '1, '0); tick("R3");
    for (int i = 0; i < 3; i++) begin
      cmd(1'b0, 1'b0, AW'(7), '0, 36'h7_7777_7777); cken_n = 1; tick("R3");
    end
    cmd(1'b0, 1'b0, AW'(8), '0, '0); tick("R3");
    cmd(1'b0, 1'b0, AW'(8), '0, 36'h3_3333_3333); cken_n = 1; tick("R3");
    cmd(1'b0, 1'b1, AW'(7), '1, 36'h8_8888_8888); tick("R3");
    cmd(1'b0, 1'b1, AW'(8), '1, '0); tick("R3");
    // R10: sleep behaves as a hold
    cmd(1'b0, 1'b0, AW'(6), '0, '0); sleep = 1; tick("R10");
    cmd(1'b0, 1'b0, AW'(10), '0, '0); tick("R10");
    cmd(1'b0, 1'b1, AW'(10), '1, 36'h5_5555_5555); sleep = 1; tick("R10");
    cmd(1'b0, 1'b1, AW'(10), '1, 36'h6_6666_6666); tick("R10");
    cmd(1'b0, 1'b1, AW'(6), '1, '0); tick("R10");

    // R4: each chip select alone blocks a load
    cmd(1'b0, 1'b1, AW'(1), '1, '0); cs1_n = 1; tick("R4");
    cmd(1'b0, 1'b1, AW'(1), '1, '0); cs2 = 0;   tick("R4");
    cmd(1'b0, 1'b1, AW'(1), '1, '0); cs3_n = 1; tick("R4");

    // R9: synchronous-looking masking, then a mid-cycle toggle
    cmd(1'b0, 1'b1, AW'(6), '1, '0); tick("R1");
    oe_n = 1; desel('0); tick("R9");
    oe_n = 0;
    cmd(1'b0, 1'b1, AW'(6), '1, '0); tick("R1");
    oe_n = 1; #0.5;
    check("R9", DW'(drive_o), '0);
    check("R9", rdata_o, '0);
    oe_n = 0; #0.5;
    check("R9", DW'(drive_o), DW'(1));
    desel('0); tick("R9");

    // random traffic over a narrow address window
    for (int i = 0; i < 3000; i++) begin
      cmd(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
          AW'($urandom_range(0, 7)), LN'($urandom), {4'($urandom), 32'($urandom)});
      if ($urandom_range(0, 9) == 0) cs2 = 0;
      if ($urandom_range(0, 9) == 0) cken_n = 1;
      if ($urandom_range(0, 19) == 0) sleep = 1;
      oe_n = ($urandom_range(0, 9) == 0);
      tick("R1");
    end

    // R12: reset mid-burst cancels the burst
    cmd(1'b0, 1'b1, AW'(2), '1, '0); oe_n = 0; tick("R1");
    rst = 1; cmd(1'b1, 1'b1, AW'(3), '1, '0); tick("R12");
    rst = 0; cmd(1'b1, 1'b1, AW'(4), '1, '0); tick("R12");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule